// File: doc/BRIEF.md
# SPI Slave Transmit Queue with Flush

This block is the transmit half of an SPI slave. A local host pushes 16-bit words into a four-entry queue. The queue feeds a transmit shift register. The external master drives the serial clock and an active-low chip select. The block shifts the committed word out most significant bit first on the data-out pin. Serial clock and chip select are brought into the system clock domain through two-flop synchronizers, so serial edges must be several system clocks apart.

The host reads a 16-bit status word. It holds the queue fill level, two sticky error flags, the synchronized chip-select state and whether the shift register holds a word. When the shift register is empty and no transfer is running, it takes the head word of the queue at once, so the reported level counts only the words waiting behind it. Driving the run control low flushes the queue. A flush never touches the word already committed to the shift register, so that stale word still goes out first. A host "load now" strobe can replace the committed word with the queue head, but only while chip select is inactive.

Top module: `spi_txq`

## Requirements
- R1: A committed word is sent most significant bit first. Its MSB appears on `spi_miso` as soon as the synchronized chip select becomes active, and each later bit follows a synchronized falling edge of `spi_sclk`. `spi_miso` is 0 while chip select is inactive.
- R2: While chip select is inactive and the shift register is empty, the queue head moves into the shift register without host action. After three writes into an idle block, the level reads 2 and status bit 3 (word loaded) is 1.
- R3: The shift register is reloaded only after its word has been shifted out by 16 falling edges. If chip select is still active at that point and the queue is not empty, the next head word is loaded at once, so words go out back to back.
- R4: Status bits 12 down to 8 hold the queue fill level, which excludes the committed word and never exceeds 4. Bits 15:13 and 7:4 read 0.
- R5: While `fifo_run` is low, the queue is emptied, the level reads 0 and host writes are dropped without raising the overflow flag. After `fifo_run` returns high, the queue stays empty until it is written.
- R6: A flush leaves the committed word and its loaded state unchanged, and the next transfer sends that word.
- R7: A write that reaches a full queue is discarded and sets sticky status bit 0 (overflow). A pulse on `err_clr` clears the bit, and a new overflow in the same cycle wins over the clear.
- R8: A falling serial clock edge during an active chip select with no committed word shifts out 0 and sets sticky status bit 1 (underrun). `err_clr` clears it.
- R9: A `load_now` pulse while chip select is inactive and the queue is not empty replaces the committed word with the queue head and removes that head. The pulse is ignored while chip select is active or the queue is empty.
- R10: Status bit 2 reads 1 while the synchronized chip select is active, and status bit 3 reads 1 while the shift register holds a committed word.
- R11: If chip select is released after 1 to 15 bits of a word, the partial word is dropped. The shift register then takes the next queue word, or reads empty if there is none.
- R12: After reset the status word is 0 and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | One-cycle push strobe |
| host_wdata | input | 16 | Word to push |
| fifo_run | input | 1 | High enables the queue; low flushes it |
| load_now | input | 1 | Replace the committed word with the queue head (chip select inactive only) |
| err_clr | input | 1 | Clears the overflow and underrun flags |
| status | output | 16 | [12:8] level, [3] word loaded, [2] chip select active, [1] underrun, [0] overflow |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low chip select from the master |
| spi_miso | output | 1 | Serial data out |

## Verification
The bench targets these corner cases:
- Three writes into an idle block. A design that counted the committed word in the level would report 3 instead of 2.
- A flush while a stale word is committed. A design that cleared the shift register would send zeros or a newer word instead of the stale one.
- A `load_now` pulse while chip select is held active, which a careless design would accept and so corrupt the word in flight.
- A write into a full queue, which must not overwrite an entry and must latch the overflow flag.
- A transfer cut off after five bits, which must drop the partial word.
- A transfer with nothing committed, which must send zeros and latch the underrun flag.

Seeded random mixes of pushes, flushes, strikes, clears and transfers then check that the level and the received words match an independent queue model.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  localparam int WORD_W  = 16;
  localparam int STAT_W  = 16;
  localparam int LVL_W   = 5;
  localparam int LVL_LSB = 8;
  localparam int ST_OVF  = 0;
  localparam int ST_UDR  = 1;
  localparam int ST_CSA  = 2;
  localparam int ST_SHV  = 3;

  // Packs the host-visible status word; unused bits read zero.
  function automatic logic [STAT_W-1:0] pack_status(
    input logic [LVL_W-1:0] lvl,
    input logic ovf,
    input logic udr,
    input logic csa,
    input logic shv
  );
    logic [STAT_W-1:0] s;
    s = '0;
    s[LVL_LSB +: LVL_W] = lvl;
    s[ST_OVF] = ovf;
    s[ST_UDR] = udr;
    s[ST_CSA] = csa;
    s[ST_SHV] = shv;
    return s;
  endfunction

  // Occupancy from wrap-bit pointers.
  function automatic logic [LVL_W-1:0] ptr_fill(
    input logic [LVL_W-1:0] wp,
    input logic [LVL_W-1:0] rp,
    input logic [LVL_W-1:0] span_mask
  );
    return (wp - rp) & span_mask;
  endfunction
endpackage

// File: rtl/spi_txq_sync.sv
module spi_txq_sync #(
  parameter int       W       = 1,
  parameter logic [0:0] RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {W{RST_VAL}};
      stage2 <= {W{RST_VAL}};
    end else begin
      stage1 <= async_i;
      stage2 <= stage1;
    end
  end

  assign sync_o = stage2;
endmodule

// File: rtl/spi_txq_fifo.sv
module spi_txq_fifo
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             drop_full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PTR_W = IDX_W + 1;
  localparam logic [LVL_W-1:0] SPAN_MASK = LVL_W'((2 * DEPTH) - 1);
  localparam logic [LVL_W-1:0] DEPTH_L   = LVL_W'(DEPTH);

  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic [DW-1:0]    slot [DEPTH];
  logic [LVL_W-1:0] fill_raw;

  assign fill_raw  = ptr_fill(LVL_W'(wptr), LVL_W'(rptr), SPAN_MASK);
  assign level     = run ? fill_raw : '0;
  assign empty     = (level == '0);
  assign full      = (level == DEPTH_L);
  assign push_ok   = push & run & ~full;
  assign drop_full = push & run & full;
  assign head      = slot[rptr[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (!run) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wptr[IDX_W-1:0] == IDX_W'(g))) slot[g] <= push_data;
    end
  end
endmodule

// File: rtl/spi_txq_shifter.sv
module spi_txq_shifter
  import spi_txq_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sclk_fall,
  input  logic          q_empty,
  input  logic [DW-1:0] q_head,
  input  logic          load_req,
  output logic          pop,
  output logic          miso,
  output logic          sh_valid,
  output logic [DW-1:0] sh_word,
  output logic          word_done,
  output logic          load_evt,
  output logic          abort_evt,
  output logic          underrun_evt
);
  localparam int CNT_W = $clog2(DW) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic shift_evt;
  logic idle_load;
  logic host_load;
  logic chain_load;

  assign shift_evt    = cs_act & sclk_fall;
  assign word_done    = shift_evt & (bit_cnt == LAST);
  assign abort_evt    = ~cs_act & (bit_cnt != '0);
  assign idle_load    = ~cs_act & ~sh_valid & ~q_empty & ~abort_evt;
  assign host_load    = ~cs_act & load_req & ~q_empty & ~abort_evt;
  assign chain_load   = word_done & ~q_empty;
  assign load_evt     = idle_load | host_load | chain_load;
  assign pop          = load_evt;
  assign underrun_evt = shift_evt & ~sh_valid;
  assign miso         = cs_act & sh_word[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      sh_valid <= 1'b0;
      sh_word  <= '0;
    end else if (abort_evt) begin
      bit_cnt  <= '0;
      sh_valid <= 1'b0;
      sh_word  <= '0;
    end else if (load_evt) begin
      bit_cnt  <= '0;
      sh_valid <= 1'b1;
      sh_word  <= q_head;
    end else if (shift_evt) begin
      sh_word <= {sh_word[DW-2:0], 1'b0};
      if (word_done) begin
        bit_cnt  <= '0;
        sh_valid <= 1'b0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_txq.sv
module spi_txq
  import spi_txq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              fifo_run,
  input  logic              load_now,
  input  logic              err_clr,
  output logic [STAT_W-1:0] status,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  output logic              spi_miso
);
  logic              sclk_s;
  logic              cs_n_s;
  logic              sclk_prev;
  logic              sclk_fall;
  logic              cs_act;
  logic [WORD_W-1:0] q_head;
  logic [LVL_W-1:0]  q_level;
  logic              q_empty;
  logic              q_full;
  logic              push_ok;
  logic              drop_full;
  logic              pop;
  logic              sh_valid;
  logic [WORD_W-1:0] sh_word;
  logic              word_done;
  logic              load_evt;
  logic              abort_evt;
  logic              underrun_evt;
  logic              ovf_flag;
  logic              udr_flag;

  spi_txq_sync #(.W(1), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_i(spi_sclk), .sync_o(sclk_s)
  );

  spi_txq_sync #(.W(1), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_i(spi_cs_n), .sync_o(cs_n_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_s;
  end

  assign sclk_fall = sclk_prev & ~sclk_s;
  assign cs_act    = ~cs_n_s;

  spi_txq_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .run(fifo_run),
    .push(host_wr), .push_data(host_wdata), .pop(pop),
    .head(q_head), .level(q_level), .empty(q_empty), .full(q_full),
    .push_ok(push_ok), .drop_full(drop_full)
  );

  spi_txq_shifter #(.DW(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .q_empty(q_empty), .q_head(q_head), .load_req(load_now), .pop(pop),
    .miso(spi_miso), .sh_valid(sh_valid), .sh_word(sh_word),
    .word_done(word_done), .load_evt(load_evt), .abort_evt(abort_evt),
    .underrun_evt(underrun_evt)
  );

  // Sticky flags: a new event in the same cycle wins over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else begin
      if (drop_full)    ovf_flag <= 1'b1;
      else if (err_clr) ovf_flag <= 1'b0;
      if (underrun_evt) udr_flag <= 1'b1;
      else if (err_clr) udr_flag <= 1'b0;
    end
  end

  assign status = pack_status(q_level, ovf_flag, udr_flag, cs_act, sh_valid);
endmodule

// File: rtl/spi_txq_chk.sv
module spi_txq_chk #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_run,
  input logic        err_clr,
  input logic        cs_act,
  input logic        sh_valid,
  input logic [15:0] sh_word,
  input logic        load_evt,
  input logic        word_done,
  input logic        abort_evt,
  input logic        drop_full,
  input logic        underrun_evt,
  input logic        ovf_flag,
  input logic        udr_flag,
  input logic [4:0]  q_level
);
  AST_LVL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= 5'(DEPTH)); // R4

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_run) |-> q_level == 5'd0); // R5

  AST_FLUSH_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_run && !cs_act && !abort_evt |=> $stable(sh_word) && $stable(sh_valid)); // R6

  AST_LOAD_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && cs_act |-> word_done); // R3

  AST_IDLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act && !sh_valid && fifo_run && q_level != 5'd0 && !abort_evt |=> sh_valid); // R2

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    drop_full |=> ovf_flag); // R7

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !err_clr |=> ovf_flag); // R7

  AST_UDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> udr_flag); // R8
endmodule

bind spi_txq spi_txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_run(fifo_run), .err_clr(err_clr),
  .cs_act(cs_act), .sh_valid(sh_valid), .sh_word(sh_word),
  .load_evt(load_evt), .word_done(word_done), .abort_evt(abort_evt),
  .drop_full(drop_full), .underrun_evt(underrun_evt),
  .ovf_flag(ovf_flag), .udr_flag(udr_flag), .q_level(q_level)
);

// File: tb/sim_spi_txq.sv
module sim_spi_txq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        fifo_run = 1'b1;
  logic        load_now = 1'b0;
  logic        err_clr = 1'b0;
  logic [15:0] status;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_miso;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Independent model
  logic [15:0] mq[$];
  bit          m_shv = 0;
  logic [15:0] m_shw = '0;
  bit          m_ovf = 0;
  bit          m_udr = 0;
  bit          m_cs = 0;

  always #10 clk = ~clk;

  spi_txq u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .fifo_run(fifo_run), .load_now(load_now), .err_clr(err_clr),
    .status(status), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_miso(spi_miso)
  );

  function automatic logic [15:0] exp_status();
    logic [15:0] v;
    v = 16'(mq.size()) << 8;
    v = v | (16'(m_shv) << 3) | (16'(m_cs) << 2) | (16'(m_udr) << 1) | 16'(m_ovf);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic model_idle_take();
    if (!m_cs && !m_shv && mq.size() > 0) begin
      m_shw = mq.pop_front();
      m_shv = 1;
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
    if (fifo_run) begin
      if (mq.size() == 4) m_ovf = 1;
      else mq.push_back(w);
      model_idle_take();
    end
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load_now = 1'b1;
    @(negedge clk);
    load_now = 1'b0;
    if (!m_cs && mq.size() > 0) begin
      m_shw = mq.pop_front();
      m_shv = 1;
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    m_ovf = 0;
    m_udr = 0;
  endtask

  task automatic do_flush(input logic [15:0] junk);
    @(negedge clk);
    fifo_run = 1'b0;
    mq.delete();
    settle();
    check("R5 level during flush", 32'(status[12:8]), 32'd0);
    push(junk);
    settle();
    check("R5 write dropped while flushing", 32'(status), 32'(exp_status()));
    fifo_run = 1'b1;
    settle();
    model_idle_take();
    check("R5 empty after release", 32'(status), 32'(exp_status()));
  endtask

  // Master transfer of nbits; idle-low clock, sample before rising edge.
  task automatic xfer(input int nbits, input string req);
    logic [15:0] got;
    logic [15:0] exp;
    got = '0;
    exp = m_shv ? m_shw : 16'h0000;
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    m_cs = 1;
    for (int i = 0; i < nbits; i++) begin
      got[15-i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (6) @(negedge clk);
      spi_sclk = 1'b0;
      repeat (6) @(negedge clk);
    end
    if (nbits > 0 && !m_shv) m_udr = 1;
    if (nbits == 16) begin
      if (mq.size() > 0) begin m_shw = mq.pop_front(); m_shv = 1; end
      else m_shv = 0;
    end else if (nbits > 0) begin
      m_shv = 0;
    end
    check({req, " received bits"}, 32'(got >> (16 - nbits)), 32'(exp >> (16 - nbits)));
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    m_cs = 0;
    model_idle_take();
    check({req, " status after transfer"}, 32'(status), 32'(exp_status()));
    check("R1 miso idle low", 32'(spi_miso), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R12 reset status", 32'(status), 32'd0);
    check("R12 reset miso", 32'(spi_miso), 32'd0);

    // R2 / R4: three back-to-back writes
    @(negedge clk);
    host_wr = 1'b1;
    for (int i = 0; i < 3; i++) begin
      host_wdata = 16'hA5C0 + 16'(i);
      mq.push_back(host_wdata);
      @(negedge clk);
    end
    host_wr = 1'b0;
    model_idle_take();
    settle();
    check("R2 level after three writes", 32'(status[12:8]), 32'd2);
    check("R4 status layout", 32'(status), 32'(exp_status()));

    // R1 / R3: first word out, next chained
    xfer(16, "R1");
    check("R3 level after word", 32'(status[12:8]), 32'd1);

    // R7: overflow
    push(16'h1111); push(16'h2222); push(16'h3333);
    settle();
    check("R4 full level", 32'(status[12:8]), 32'd4);
    push(16'hDEAD);
    settle();
    check("R7 overflow flag", 32'(status), 32'(exp_status()));
    pulse_clear();
    check("R7 cleared", 32'(status[0]), 32'd0);

    // R5 / R6: flush keeps committed word
    do_flush(16'hBEEF);
    check("R6 word still loaded", 32'(status[3]), 32'd1);
    xfer(16, "R6");

    // R8: underrun
    xfer(16, "R8");
    check("R8 underrun flag", 32'(status[1]), 32'd1);
    pulse_clear();
    check("R8 cleared", 32'(status[1]), 32'd0);

    // R9: load_now while idle
    push(16'h4C4C); push(16'h5A5A);
    pulse_load();
    settle();
    check("R9 head replaces word", 32'(status), 32'(exp_status()));
    xfer(16, "R9");

    // R9 / R10: load_now ignored with chip select active
    push(16'h6E6E); push(16'h7F7F);
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    m_cs = 1;
    check("R10 cs active status", 32'(status), 32'(exp_status()));
    pulse_load();
    settle();
    check("R9 ignored during cs", 32'(status[12:8]), 32'd1);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    m_cs = 0;
    xfer(16, "R9 kept");

    // R11: aborted transfer drops partial word
    xfer(5, "R11");
    check("R11 word dropped", 32'(status[3]), 32'd0);
    xfer(16, "R8 after abort");
    pulse_clear();

    // Constrained random mix
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 70; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 5)       push(16'($urandom));
      else if (op == 5) do_flush(16'($urandom));
      else if (op == 6) pulse_load();
      else if (op == 7) pulse_clear();
      else              xfer(($urandom % 4 == 0) ? 7 : 16, "R3 random");
      settle();
      check("R4 random status", 32'(status), 32'(exp_status()));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule